// File: doc/BRIEF.md
# Loadable Lookup-Table Logic Slice

This block is a logic element whose function is not wired in gates. It is held as a truth table in a small synchronous RAM. A loader first takes over the table in a configuration phase. It drives a table address and a data word, and pulses a write strobe, so it can store any function of the inputs. When the loader signals that configuration is complete, the block switches to operating use. The functional inputs then form the table address, and the word stored there comes out one clock later.

The sample arrangement is an operation slice with two operands and an operation code. Together they form the table address. The low bits of each stored word are the result. The bits above the result are side outputs, such as a carry or a propagate, that a neighbouring slice can chain on.

The memory holds 2^(2·OPND_W+SEL_W) entries. The default operand width is 4 bits, which gives 4096 words of 16 bits. Setting OPND_W=6 gives the full 16-bit-address slice. WORD_W must be larger than OPND_W.

Top module: `lut_slice_top`

## Requirements
- R1: While reset is asserted, `ready`, `result` and `side_out` are all zero.
- R2: When operating (`cfg_mode`=0), the table address is {`op_code`, `opnd_l`, `opnd_r`}, with the code in the top bits, L in the middle and R in the low bits. The addressed word appears on the outputs exactly one clock after the inputs are sampled, and the outputs do not change between edges.
- R3: When `cfg_mode`=1, the table address is `cfg_addr`, and the word stored there appears on the outputs one clock later (readback).
- R4: The table is written only when `cfg_mode`=1 and `cfg_we`=1. A strobe on `cfg_we` while `cfg_mode`=0 leaves every entry unchanged.
- R5: A write and a read of the same address in the same cycle return the newly written word on the next clock.
- R6: `ready` goes to 1 on the clock after `cfg_done` is sampled high. It then holds its value while `cfg_mode` and `cfg_done` are both low. `ready` stays 0 throughout loading, until `cfg_done` is given.
- R7: Sampling `cfg_mode`=1 with `cfg_done`=0 clears `ready` on the next clock. Entries already loaded are kept.
- R8: `result` is bits [OPND_W-1:0] of the addressed word. `side_out` is bits [WORD_W-1:OPND_W].
- R9: With the sample table loaded, codes 0 to 13 give the following results, all modulo 2^OPND_W: L+R, L−R, R−L, NOT L, AND, NAND, OR, NOR, XOR, L AND NOT R, the low half of L×R, the high half of L×R, L rotated left by R mod 4, and L bit-reversed when R[0]=1 (else L unchanged).
- R10: In the sample table, side bit 0 holds the carry out for code 0 and the borrow for codes 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_mode | input | 1 | 1 = loader owns the table address; 0 = functional inputs do |
| cfg_done | input | 1 | Loader strobe marking that configuration is complete |
| cfg_we | input | 1 | Table write strobe, honoured only when cfg_mode is 1 |
| cfg_addr | input | 2*OPND_W+SEL_W | Loader table address |
| cfg_data | input | WORD_W | Loader write word |
| opnd_l | input | OPND_W | Left operand |
| opnd_r | input | OPND_W | Right operand |
| op_code | input | SEL_W | Operation code |
| result | output | OPND_W | Low field of the registered table word |
| side_out | output | WORD_W-OPND_W | Upper field of the registered table word, for chaining |
| ready | output | 1 | Outputs reflect a completed configuration |

## Verification
The bench writes a word and reads the same address in the same cycle. A table with a read-before-write RAM would return the stale entry there. It strobes `cfg_we` while operating and then reads that entry through the operands; a design that honours the strobe returns the stray word instead of the table value. It checks the outputs between edges and after exactly one edge, which exposes a combinational read or an extra pipeline stage. It also drops back into configuration after `ready` is set, which catches a `ready` that sticks or a table that is cleared. Operand pairs at zero, all-ones and mixed values for every code, including carries and borrows, catch a swapped address field or a misplaced result/side split.

// File: rtl/lut_slice_pkg.sv
package lut_slice_pkg;
  localparam int unsigned OPND_W_DEF = 4;
  localparam int unsigned SEL_W_DEF  = 4;
  localparam int unsigned WORD_W_DEF = 16;

  typedef enum logic {
    SRC_FUNC   = 1'b0,
    SRC_LOADER = 1'b1
  } addr_src_e;
endpackage

// File: rtl/lut_rst_sync.sv
module lut_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/lut_addr_sel.sv
module lut_addr_sel
  import lut_slice_pkg::*;
#(
  parameter int unsigned OPND_W = OPND_W_DEF,
  parameter int unsigned SEL_W  = SEL_W_DEF,
  localparam int unsigned ADDR_W = 2*OPND_W + SEL_W
) (
  input  logic              cfg_mode,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [OPND_W-1:0] opnd_l,
  input  logic [OPND_W-1:0] opnd_r,
  input  logic [SEL_W-1:0]  op_code,
  output logic [ADDR_W-1:0] rd_addr
);
  addr_src_e src;
  logic [ADDR_W-1:0] func_addr;

  assign src       = cfg_mode ? SRC_LOADER : SRC_FUNC;
  assign func_addr = {op_code, opnd_l, opnd_r};

  always_comb begin
    unique case (src)
      SRC_LOADER: rd_addr = cfg_addr;
      default:    rd_addr = func_addr;
    endcase
  end
endmodule

// File: rtl/lut_table_ram.sv
module lut_table_ram #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_d;
  logic [WORD_W-1:0] rd_q;
  logic              hit;

  assign hit = wr_en && (wr_addr == rd_addr);

  always_comb begin
    if (hit) rd_d = wr_data;
    else     rd_d = mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_word = rd_q;
endmodule

// File: rtl/lut_ready_ctl.sv
module lut_ready_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_mode,
  input  logic cfg_done,
  output logic ready
);
  logic rdy_q;
  logic rdy_d;

  always_comb begin
    rdy_d = rdy_q;
    if (cfg_done)      rdy_d = 1'b1;
    else if (cfg_mode) rdy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= rdy_d;
  end

  assign ready = rdy_q;
endmodule

// File: rtl/lut_slice_top.sv
module lut_slice_top
  import lut_slice_pkg::*;
#(
  parameter int unsigned OPND_W = OPND_W_DEF,
  parameter int unsigned SEL_W  = SEL_W_DEF,
  parameter int unsigned WORD_W = WORD_W_DEF,
  localparam int unsigned ADDR_W = 2*OPND_W + SEL_W,
  localparam int unsigned SIDE_W = WORD_W - OPND_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mode,
  input  logic              cfg_done,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_data,
  input  logic [OPND_W-1:0] opnd_l,
  input  logic [OPND_W-1:0] opnd_r,
  input  logic [SEL_W-1:0]  op_code,
  output logic [OPND_W-1:0] result,
  output logic [SIDE_W-1:0] side_out,
  output logic              ready
);
  logic              rst_q_n;
  logic              wr_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_word;

  lut_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  // write enable is the table's clock enable; loader writes only in config
  assign wr_en = cfg_mode & cfg_we;

  lut_addr_sel #(.OPND_W(OPND_W), .SEL_W(SEL_W)) addr_sel_i (
    .cfg_mode (cfg_mode),
    .cfg_addr (cfg_addr),
    .opnd_l   (opnd_l),
    .opnd_r   (opnd_r),
    .op_code  (op_code),
    .rd_addr  (rd_addr)
  );

  lut_table_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) table_i (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_en   (wr_en),
    .wr_addr (cfg_addr),
    .wr_data (cfg_data),
    .rd_addr (rd_addr),
    .rd_word (rd_word)
  );

  lut_ready_ctl ready_i (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .cfg_mode (cfg_mode),
    .cfg_done (cfg_done),
    .ready    (ready)
  );

  assign result   = rd_word[OPND_W-1:0];
  assign side_out = rd_word[WORD_W-1:OPND_W];
endmodule

// File: rtl/lut_slice_chk.sv
module lut_slice_chk #(
  parameter int unsigned OPND_W = 4,
  parameter int unsigned WORD_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_mode,
  input logic                     cfg_done,
  input logic                     cfg_we,
  input logic [WORD_W-1:0]        cfg_data,
  input logic [OPND_W-1:0]        result,
  input logic [WORD_W-OPND_W-1:0] side_out,
  input logic                     ready
);
  // R5: same-cycle write and readback returns the new word
  a_r5_write_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && cfg_we) |=> ({side_out, result} == $past(cfg_data)));

  // R6: completion strobe raises ready on the next clock
  a_r6_ready_set: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> ready);

  // R6: ready holds when neither strobe nor config mode is present
  a_r6_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && !cfg_done) |=> (ready == $past(ready)));

  // R6: ready only ever rises because of the completion strobe
  a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(cfg_done));

  // R7: re-entering config without completion drops ready
  a_r7_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && !cfg_done) |=> !ready);
endmodule

bind lut_slice_top lut_slice_chk #(.OPND_W(OPND_W), .WORD_W(WORD_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .cfg_mode (cfg_mode),
  .cfg_done (cfg_done),
  .cfg_we   (cfg_we),
  .cfg_data (cfg_data),
  .result   (result),
  .side_out (side_out),
  .ready    (ready)
);

// File: tb/lut_slice_top_tb.sv
module lut_slice_top_tb_top;
  localparam int OW = 4;
  localparam int SW = 4;
  localparam int WW = 16;
  localparam int AW = 2*OW + SW;

  logic          clk;
  logic          rst_n;
  logic          cfg_mode, cfg_done, cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [WW-1:0] cfg_data;
  logic [OW-1:0] opnd_l, opnd_r;
  logic [SW-1:0] op_code;
  logic [OW-1:0] result;
  logic [WW-OW-1:0] side_out;
  logic          ready;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  lut_slice_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_done(cfg_done),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .opnd_l(opnd_l), .opnd_r(opnd_r), .op_code(op_code),
    .result(result), .side_out(side_out), .ready(ready)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] golden(input logic [3:0] s, input logic [3:0] l,
                                         input logic [3:0] r);
    logic [4:0]  t;
    logic [7:0]  p;
    logic [7:0]  rot;
    logic [3:0]  res;
    logic [11:0] sd;
    sd  = 12'h000;
    t   = 5'd0;
    p   = {4'd0, l} * {4'd0, r};
    rot = {l, l} << r[1:0];
    case (s)
      4'd0:  begin t = {1'b0, l} + {1'b0, r}; res = t[3:0]; sd[0] = t[4]; end
      4'd1:  begin t = {1'b0, l} - {1'b0, r}; res = t[3:0]; sd[0] = t[4]; end
      4'd2:  begin t = {1'b0, r} - {1'b0, l}; res = t[3:0]; sd[0] = t[4]; end
      4'd3:  res = ~l;
      4'd4:  res = l & r;
      4'd5:  res = ~(l & r);
      4'd6:  res = l | r;
      4'd7:  res = ~(l | r);
      4'd8:  res = l ^ r;
      4'd9:  res = l & ~r;
      4'd10: res = p[3:0];
      4'd11: res = p[7:4];
      4'd12: res = rot[7:4];
      4'd13: res = r[0] ? {l[0], l[1], l[2], l[3]} : l;
      default: res = 4'd0;
    endcase
    return {sd, res};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic op_step(input string req, input logic [3:0] s, input logic [3:0] l,
                         input logic [3:0] r);
    @(negedge clk);
    op_code = s; opnd_l = l; opnd_r = r;
    @(negedge clk);
    chk(req, {side_out, result}, golden(s, l, r));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cfg_mode = 1'b0; cfg_done = 1'b0; cfg_we = 1'b0;
    cfg_addr = '0; cfg_data = '0; opnd_l = '0; opnd_r = '0; op_code = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready", {15'd0, ready}, 16'd0);
    chk("R1 result", {12'd0, result}, 16'd0);
    chk("R1 side", {4'd0, side_out}, 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_load;
    cfg_mode = 1'b1;
    for (int a = 0; a < (1 << AW); a++) begin
      cfg_addr = a[AW-1:0];
      cfg_data = golden(cfg_addr[11:8], cfg_addr[7:4], cfg_addr[3:0]);
      cfg_we = 1'b1;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    chk("R6 not ready during load", {15'd0, ready}, 16'd0);
    cfg_addr = 12'h5A3;
    @(negedge clk);
    chk("R3 readback 5A3", {side_out, result}, golden(4'h5, 4'hA, 4'h3));
    cfg_addr = 12'h0F1;
    @(negedge clk);
    chk("R3 readback 0F1", {side_out, result}, golden(4'h0, 4'hF, 4'h1));
    chk("R8 result field", {12'd0, result}, {12'd0, golden(4'h0, 4'hF, 4'h1) & 16'h000F});
    chk("R8 side field", {4'd0, side_out}, {4'd0, golden(4'h0, 4'hF, 4'h1) >> 4});
  endtask

  task automatic t_raw;
    @(negedge clk);
    cfg_addr = 12'h123; cfg_data = 16'hBEEF; cfg_we = 1'b1;
    @(negedge clk);
    chk("R5 write-first", {side_out, result}, 16'hBEEF);
    cfg_data = golden(4'h1, 4'h2, 4'h3);
    @(negedge clk);
    chk("R5 rewrite", {side_out, result}, golden(4'h1, 4'h2, 4'h3));
    cfg_we = 1'b0;
  endtask

  task automatic t_ready;
    @(negedge clk);
    cfg_mode = 1'b0; cfg_done = 1'b1;
    #1 chk("R6 not yet ready", {15'd0, ready}, 16'd0);
    @(negedge clk);
    cfg_done = 1'b0;
    chk("R6 ready set", {15'd0, ready}, 16'd1);
    repeat (3) @(negedge clk);
    chk("R6 ready held", {15'd0, ready}, 16'd1);
  endtask

  task automatic t_latency;
    op_step("R2 address order", 4'd1, 4'd9, 4'd2);
    op_code = 4'd8; opnd_l = 4'd5; opnd_r = 4'd3;
    #2 chk("R2 no change before edge", {side_out, result}, golden(4'd1, 4'd9, 4'd2));
    @(negedge clk);
    chk("R2 one-cycle latency", {side_out, result}, golden(4'd8, 4'd5, 4'd3));
  endtask

  task automatic t_ops;
    logic [3:0] ls [5] = '{4'd0, 4'd15, 4'd9, 4'd3, 4'd7};
    logic [3:0] rs [5] = '{4'd0, 4'd15, 4'd6, 4'd12, 4'd1};
    for (int s = 0; s < 14; s++)
      for (int k = 0; k < 5; k++)
        op_step($sformatf("R9 code %0d", s), s[3:0], ls[k], rs[k]);
  endtask

  task automatic t_carry;
    @(negedge clk);
    op_code = 4'd0; opnd_l = 4'd15; opnd_r = 4'd1;
    @(negedge clk);
    chk("R10 carry out", {15'd0, side_out[0]}, 16'd1);
    op_code = 4'd1; opnd_l = 4'd2; opnd_r = 4'd5;
    @(negedge clk);
    chk("R10 borrow L-R", {15'd0, side_out[0]}, 16'd1);
    op_code = 4'd2; opnd_l = 4'd2; opnd_r = 4'd5;
    @(negedge clk);
    chk("R10 no borrow R-L", {15'd0, side_out[0]}, 16'd0);
    op_code = 4'd0; opnd_l = 4'd3; opnd_r = 4'd4;
    @(negedge clk);
    chk("R10 no carry", {15'd0, side_out[0]}, 16'd0);
  endtask

  task automatic t_ignore;
    @(negedge clk);
    cfg_addr = {4'd4, 4'd6, 4'd3}; cfg_data = 16'h0F0F; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    op_step("R4 write ignored when operating", 4'd4, 4'd6, 4'd3);
  endtask

  task automatic t_drop;
    @(negedge clk);
    cfg_mode = 1'b1; cfg_addr = 12'hA7C;
    @(negedge clk);
    chk("R7 ready dropped", {15'd0, ready}, 16'd0);
    chk("R7 table kept", {side_out, result}, golden(4'hA, 4'h7, 4'hC));
    cfg_mode = 1'b0; cfg_done = 1'b1;
    @(negedge clk);
    cfg_done = 1'b0;
    chk("R7 ready restored", {15'd0, ready}, 16'd1);
    op_step("R7 operate after reconfig", 4'd11, 4'd13, 4'd14);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_load();
    t_raw();
    t_ready();
    t_latency();
    t_ops();
    t_carry();
    t_ignore();
    t_drop();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule